// File: doc/BRIEF.md
# Bit-Reversed Counter Pulse-Width Modulator

This block turns an (N+1)-bit level into a one-bit stream whose share of high cycles per frame equals level / 2^N. A free-running N-bit counter defines frames of 2^N clocks. In spread mode the level is compared with the counter after its bit order has been mirrored, rather than with the counter itself. The high cycles of a frame are then scattered across the frame instead of forming one block. Output energy moves up in frequency, so a simpler analog low-pass filter is enough after the pin. A plain mode compares against the unmirrored count and gives the classic single pulse with the same duty, for comparison.

The level and the mode select are captured only on the clock edge that begins a frame. A one-cycle strobe marks the first cycle of each frame. Control is a two-state machine. ST_IDLE holds the counter at zero with both outputs low, and captures the inputs. Transition T_START always moves it to ST_RUN after one cycle. In ST_RUN, transition T_STEP advances the counter. Transition T_WRAP, taken on the last count, recaptures the inputs as the counter rolls over to zero.

Top module: `bitrev_pwm`

## Requirements
- R1: While reset is asserted, and in the single ST_IDLE cycle that follows its release, pwm_out and frame_start are both 0.
- R2: From the first frame on, frame_start is high for exactly one cycle in every 2^N cycles, and only in the cycle where the frame position is 0.
- R3: With the captured mode at 1 (spread), pwm_out at frame position p is 1 exactly when the value of p with its N bits in mirrored order (bit i moved to bit N-1-i), zero-extended, is below the captured level.
- R4: With the captured mode at 0 (plain), pwm_out at frame position p is 1 exactly when p is below the captured level, so for 0 < level < 2^N the output falls once within the frame.
- R5: In both modes, the number of high cycles in every frame equals the captured level, for every level from 0 to 2^N.
- R6: A captured level of 0 keeps pwm_out low for the whole frame, and a level of 2^N keeps it high for the whole frame.
- R7: In spread mode with level 2^(N-1), pwm_out changes value on every clock inside the frame.
- R8: level and spread_mode are sampled only on the edge that starts a frame; changing them at any other time has no effect on the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| spread_mode | input | 1 | 1 selects mirrored-count compare, 0 selects plain compare |
| level | input | CNT_W+1 | Duty level, 0 to 2^CNT_W |
| pwm_out | output | 1 | Modulated output |
| frame_start | output | 1 | High in the first cycle of each frame |

## Verification
Every level from 0 to 2^N runs for one frame in spread mode. Each frame is compared cycle by cycle against the mirrored-count rule and against the high-cycle total. This separates a correct mirror from a plain or partly reversed compare, because the totals agree but the placement does not. A set of plain-mode levels around 0, 1, the midpoint and full scale tells an off-by-one in the compare or in the N+1-bit width apart from correct behaviour. Midpoint frames in both modes show the every-clock toggle against the single fall. In each frame the inputs hold inverted junk values until mid-frame before they settle, which exposes any capture outside the frame boundary.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwmr_state_t;

endpackage

// File: rtl/pwmr_counter.sv
module pwmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] count,
    output logic         last
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    assign last = run && (count == TOP);
endmodule

// File: rtl/pwmr_mirror.sv
module pwmr_mirror #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_swap
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/pwmr_compare.sv
module pwmr_compare #(
    parameter int W = 8
) (
    input  logic [W-1:0] straight,
    input  logic [W-1:0] mirrored,
    input  logic         use_mirror,
    input  logic [W:0]   thresh,
    output logic         below
);
    logic [W-1:0] pick;

    always_comb begin
        pick  = use_mirror ? mirrored : straight;
        below = ({1'b0, pick} < thresh);
    end
endmodule

// File: rtl/bitrev_pwm.sv
module bitrev_pwm
    import pwmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spread_mode,
    input  logic [CNT_W:0]   level,
    output logic             pwm_out,
    output logic             frame_start
);
    pwmr_state_t      state_q;
    pwmr_state_t      state_d;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] pos_mir;
    logic             pos_last;
    logic             run;
    logic             capture;
    logic             hit;
    logic [CNT_W:0]   lvl_q;
    logic             mode_q;

    pwmr_counter #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .count (pos),
        .last  (pos_last)
    );

    pwmr_mirror #(.W(CNT_W)) u_mirror (
        .din  (pos),
        .dout (pos_mir)
    );

    pwmr_compare #(.W(CNT_W)) u_cmp (
        .straight   (pos),
        .mirrored   (pos_mir),
        .use_mirror (mode_q),
        .thresh     (lvl_q),
        .below      (hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_START from idle, T_STEP / T_WRAP stay in run
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        run         = 1'b0;
        capture     = 1'b0;
        frame_start = 1'b0;
        pwm_out     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture = 1'b1;
            end
            ST_RUN: begin
                run         = 1'b1;
                capture     = pos_last;
                frame_start = (pos == '0);
                pwm_out     = hit;
            end
            default: begin
                capture = 1'b0;
            end
        endcase
    end

    // frame-boundary capture of the control inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            mode_q <= 1'b0;
        end else if (capture) begin
            lvl_q  <= level;
            mode_q <= spread_mode;
        end
    end
endmodule

// File: rtl/pwmr_checker.sv
module pwmr_checker
    import pwmr_pkg::*;
#(
    parameter int N = 8
) (
    input logic        clk,
    input logic        rst_n,
    input pwmr_state_t state_q,
    input logic [N:0]  lvl_q,
    input logic        mode_q,
    input logic        pwm_out,
    input logic        frame_start
);
    localparam logic [N:0] FULL = (N+1)'(1) << N;
    localparam logic [N:0] HALF = (N+1)'(1) << (N-1);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!pwm_out && !frame_start)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R2

    AST_FIRST_SLOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && lvl_q != '0) |-> pwm_out); // R3

    AST_CAPTURE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> ($stable(lvl_q) && $stable(mode_q))); // R8

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == '0) |-> !pwm_out); // R6

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && lvl_q == FULL) |-> pwm_out); // R6

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_q && lvl_q == HALF && !frame_start)
            |-> (pwm_out != $past(pwm_out))); // R7
endmodule

bind bitrev_pwm pwmr_checker #(.N(CNT_W)) u_pwmr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .lvl_q       (lvl_q),
    .mode_q      (mode_q),
    .pwm_out     (pwm_out),
    .frame_start (frame_start)
);

// File: tb/tb_bitrev_pwm.sv
module tb_bitrev_pwm;
    localparam int  N          = 8;
    localparam int  FULL       = 1 << N;
    localparam int  HALF       = FULL / 2;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spread_mode = 1'b1;
    logic [N:0] level = '0;
    wire        pwm_out;
    wire        frame_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitrev_pwm #(.CNT_W(N)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spread_mode (spread_mode),
        .level       (level),
        .pwm_out     (pwm_out),
        .frame_start (frame_start)
    );

    typedef struct {
        int lvl;
        bit rev;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    function automatic int mirror(input int v);
        int r = 0;
        for (int i = 0; i < N; i++) begin
            if (v[i]) r |= 1 << (N-1-i);
        end
        return r;
    endfunction

    // driver: junk until mid-frame, then the real value for the next frame
    task automatic apply(input int lvl, input bit rev);
        item_t it;
        do @(negedge clk); while (!frame_start);
        level       = ~lvl[N:0];
        spread_mode = ~rev;
        it.lvl = lvl;
        it.rev = rev;
        exp_q.push_back(it);
        repeat (90) @(negedge clk);
        level       = lvl[N:0];
        spread_mode = rev;
    endtask

    // monitor / scoreboard
    int    pos = 0;
    int    hi = 0;
    int    mism = 0;
    int    tog = 0;
    bit    prev = 1'b0;
    bit    have = 1'b0;
    item_t cur;

    task automatic close_frame();
        if (cur.lvl >= 0) begin
            check(pos == FULL, "R2", "frame length", pos, FULL);
            check(hi == cur.lvl, "R5", $sformatf("high count rev=%0d", cur.rev), hi, cur.lvl);
            check(mism == 0, cur.rev ? "R3/R8" : "R4/R8",
                  $sformatf("waveform mismatches level=%0d", cur.lvl), mism, 0);
            if (cur.lvl == 0 || cur.lvl == FULL)
                check(hi == cur.lvl, "R6", "constant level high count", hi, cur.lvl);
            if (cur.rev && cur.lvl == HALF)
                check(tog == FULL-1, "R7", "toggles in midpoint spread frame", tog, FULL-1);
            if (!cur.rev && cur.lvl > 0 && cur.lvl < FULL)
                check(tog == 1, "R4", "edges inside plain frame", tog, 1);
            void'(exp_q.pop_front());
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start) begin
                if (have) close_frame();
                have = 1'b1;
                pos = 0; hi = 0; mism = 0; tog = 0;
                if (exp_q.size() > 0) cur = exp_q[0];
                else begin cur.lvl = -1; cur.rev = 1'b0; end
            end
            if (have) begin
                bit e;
                e = cur.rev ? (mirror(pos) < cur.lvl) : (pos < cur.lvl);
                if (pwm_out !== e) mism++;
                if (pwm_out) hi++;
                if (pos > 0 && pwm_out != prev) tog++;
                prev = pwm_out;
                pos++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        item_t first;
        int plain_set[12] = '{0, 1, 2, 127, 128, 129, 200, 254, 255, 256, 64, 128};
        level       = HALF[N:0];
        spread_mode = 1'b1;
        first.lvl = HALF;
        first.rev = 1'b1;
        exp_q.push_back(first);
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1", "pwm_out in reset", pwm_out, 0);
        check(frame_start == 1'b0, "R1", "frame_start in reset", frame_start, 0);
        rst_n = 1'b1;
        #1;
        check(pwm_out == 1'b0, "R1", "pwm_out in idle cycle", pwm_out, 0);
        check(frame_start == 1'b0, "R1", "frame_start in idle cycle", frame_start, 0);
        for (int v = 0; v <= FULL; v++) apply(v, 1'b1);
        foreach (plain_set[i]) apply(plain_set[i], 1'b0);
        apply(HALF, 1'b1);
        while (exp_q.size() > 0) @(negedge clk);
        summary();
        $finish;
    end
endmodule